// File: doc/BRIEF.md
# Hardware Thread Yield Controller

This block carries out a yield request issued by one of several hardware thread contexts. The caller supplies its context number, a signed source operand and a mask of the wait conditions it may use. The block also takes per-context status bits and one element-level intercept enable. The sign and value of the source operand select one of four paths:

- A zero operand asks to release the calling context.
- A positive operand names wait conditions, and each one must be allowed by the mask.
- The value minus two is a no-operation.
- Any other negative operand is a privileged yield that the element may intercept.

Each request takes one clock cycle. On the cycle after the request, the block returns the operand masked by the yield mask. Depending on the path, it also pulses a fault with a held exception code, or pulses a request to clear the caller's activated bit. Suspending the thread and choosing another context to run belong to the surrounding core.

Top module: `yield_ctl`

## Requirements
- R1: After reset is released, `rsp_valid`, `fault`, `deact_valid` and `result` are zero, and `exc_code` is 0.
- R2: A request sampled at a rising clock edge makes `rsp_valid` high for exactly the following cycle. In that cycle `result` equals `yield_src & yield_mask`, whatever path was taken.
- R3: A zero operand from a caller whose dynamic-allocation bit is 1, halt bit is 0 and activated bit is 1 pulses `deact_valid` for one cycle with `deact_ctx` equal to the caller, and it raises no fault (`exc_code` 0).
- R4: A zero operand from a caller that does not meet all three conditions of R3 gives no `deact_valid`, no fault and `exc_code` 0.
- R5: A positive operand with any bit set outside `yield_mask` pulses `fault` and sets `exc_code` to 2.
- R6: A positive operand whose set bits all lie inside `yield_mask` gives no fault and `exc_code` 0.
- R7: A negative operand other than -2 pulses `fault` with `exc_code` 4 when `intercept_en` is 1 and the caller's dirty bit is 1. Otherwise it gives no fault and `exc_code` 0.
- R8: The operand -2 never faults and never pulses `deact_valid`, and it sets `exc_code` to 0.
- R9: `fault` and `deact_valid` are single-cycle pulses that never occur together. `exc_code` keeps its value on every cycle without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Yield request strobe |
| req_ctx | input | CW | Calling context number |
| yield_src | input | DW | Signed source operand |
| yield_mask | input | DW | Permitted wait-condition mask |
| ctx_dyn | input | N_CTX | Per-context dynamic-allocation bit |
| ctx_halt | input | N_CTX | Per-context halt bit |
| ctx_act | input | N_CTX | Per-context activated bit |
| ctx_dirty | input | N_CTX | Per-context dirty bit |
| intercept_en | input | 1 | Element-level privileged-yield intercept enable |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| result | output | DW | Operand AND mask |
| fault | output | 1 | Thread fault pulse |
| exc_code | output | 3 | Exception code of the latest request |
| deact_valid | output | 1 | Pulse that clears the caller's activated bit |
| deact_ctx | output | CW | Context whose activated bit is cleared |

## Verification
Two outputs can change together on one response cycle: a non-zero masked `result` and a code-2 fault. Requests with a positive operand carrying bits both inside and outside the mask provoke this, and the bench checks both values on that same cycle.

A second overlap comes from back-to-back requests. A release in one cycle followed by a faulting request in the next must show the two pulses on consecutive cycles, never together. Idle cycles between requests then confirm that the exception code stays held.

// File: rtl/yc_pkg.sv
package yc_pkg;
  typedef enum logic [1:0] {
    PATH_RELEASE = 2'd0,
    PATH_WAIT    = 2'd1,
    PATH_PRIV    = 2'd2,
    PATH_NOP     = 2'd3
  } yc_path_e;

  localparam logic [2:0] EXC_NONE = 3'd0;
  localparam logic [2:0] EXC_WAIT = 3'd2;
  localparam logic [2:0] EXC_PRIV = 3'd4;
endpackage

// File: rtl/yc_classify.sv
module yc_classify #(
  parameter int DW = 32
) (
  input  logic signed [DW-1:0] src,
  input  logic        [DW-1:0] mask,
  output yc_pkg::yc_path_e     path,
  output logic                 wait_illegal
);
  localparam logic signed [DW-1:0] NEG_TWO = -2;

  always_comb begin
    if (src == '0)            path = yc_pkg::PATH_RELEASE;
    else if (!src[DW-1])      path = yc_pkg::PATH_WAIT;
    else if (src == NEG_TWO)  path = yc_pkg::PATH_NOP;
    else                      path = yc_pkg::PATH_PRIV;
  end

  assign wait_illegal = |(src & ~mask);
endmodule

// File: rtl/yc_ctx_pick.sv
module yc_ctx_pick #(
  parameter int N_CTX = 4,
  parameter int CW    = 2
) (
  input  logic [CW-1:0]    sel,
  input  logic [N_CTX-1:0] dyn_v,
  input  logic [N_CTX-1:0] halt_v,
  input  logic [N_CTX-1:0] act_v,
  input  logic [N_CTX-1:0] dirty_v,
  output logic             dyn,
  output logic             halt,
  output logic             act,
  output logic             dirty
);
  logic [N_CTX-1:0] hit;

  genvar i;
  generate
    for (i = 0; i < N_CTX; i++) begin : g_dec
      assign hit[i] = (sel == CW'(i));
    end
  endgenerate

  assign dyn   = |(hit & dyn_v);
  assign halt  = |(hit & halt_v);
  assign act   = |(hit & act_v);
  assign dirty = |(hit & dirty_v);
endmodule

// File: rtl/yield_ctl.sv
module yield_ctl #(
  parameter int N_CTX = 4,
  parameter int DW    = 32,
  parameter int CW    = (N_CTX > 1) ? $clog2(N_CTX) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic [CW-1:0]        req_ctx,
  input  logic signed [DW-1:0] yield_src,
  input  logic [DW-1:0]        yield_mask,
  input  logic [N_CTX-1:0]     ctx_dyn,
  input  logic [N_CTX-1:0]     ctx_halt,
  input  logic [N_CTX-1:0]     ctx_act,
  input  logic [N_CTX-1:0]     ctx_dirty,
  input  logic                 intercept_en,
  output logic                 rsp_valid,
  output logic [DW-1:0]        result,
  output logic                 fault,
  output logic [2:0]           exc_code,
  output logic                 deact_valid,
  output logic [CW-1:0]        deact_ctx
);
  import yc_pkg::*;

  yc_path_e path;
  logic     wait_illegal;
  logic     c_dyn, c_halt, c_act, c_dirty;
  logic     nxt_fault, nxt_deact;
  logic [2:0] nxt_code;

  yc_classify #(.DW(DW)) u_cls (
    .src(yield_src), .mask(yield_mask),
    .path(path), .wait_illegal(wait_illegal)
  );

  yc_ctx_pick #(.N_CTX(N_CTX), .CW(CW)) u_pick (
    .sel(req_ctx), .dyn_v(ctx_dyn), .halt_v(ctx_halt),
    .act_v(ctx_act), .dirty_v(ctx_dirty),
    .dyn(c_dyn), .halt(c_halt), .act(c_act), .dirty(c_dirty)
  );

  always_comb begin
    nxt_fault = 1'b0;
    nxt_deact = 1'b0;
    nxt_code  = EXC_NONE;
    unique case (path)
      PATH_RELEASE: nxt_deact = c_dyn & ~c_halt & c_act;
      PATH_WAIT: if (wait_illegal) begin
        nxt_fault = 1'b1;
        nxt_code  = EXC_WAIT;
      end
      PATH_PRIV: if (intercept_en && c_dirty) begin
        nxt_fault = 1'b1;
        nxt_code  = EXC_PRIV;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      result      <= '0;
      fault       <= 1'b0;
      exc_code    <= EXC_NONE;
      deact_valid <= 1'b0;
      deact_ctx   <= '0;
    end else begin
      rsp_valid   <= req_valid;
      fault       <= req_valid & nxt_fault;
      deact_valid <= req_valid & nxt_deact;
      if (req_valid) begin
        result    <= yield_src & yield_mask;
        exc_code  <= nxt_code;
        deact_ctx <= req_ctx;
      end
    end
  end
endmodule

// File: rtl/yc_chk.sv
module yc_chk #(
  parameter int N_CTX = 4,
  parameter int DW    = 32,
  parameter int CW    = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 req_valid,
  input logic [CW-1:0]        req_ctx,
  input logic signed [DW-1:0] yield_src,
  input logic [DW-1:0]        yield_mask,
  input logic                 intercept_en,
  input logic                 rsp_valid,
  input logic [DW-1:0]        result,
  input logic                 fault,
  input logic [2:0]           exc_code,
  input logic                 deact_valid,
  input logic [CW-1:0]        deact_ctx
);
  p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  p_result_masked_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (result == $past(yield_src & yield_mask)));
  p_release_zero_src_r3: assert property (@(posedge clk) disable iff (rst)
    deact_valid |-> ($past(yield_src) == '0 && deact_ctx == $past(req_ctx)));
  p_wait_code_r5: assert property (@(posedge clk) disable iff (rst)
    (fault && exc_code == 3'd2) |-> !$past(yield_src[DW-1]));
  p_nop_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && yield_src == -2) |=> (!fault && !deact_valid && exc_code == 3'd0));
  p_fault_code_r9: assert property (@(posedge clk) disable iff (rst)
    fault |-> (rsp_valid && (exc_code == 3'd2 || exc_code == 3'd4)));
  p_no_overlap_r9: assert property (@(posedge clk) disable iff (rst)
    !(fault && deact_valid));
  p_code_held_r9: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> ($stable(exc_code) && !rsp_valid && !fault && !deact_valid));
endmodule

bind yield_ctl yc_chk #(.N_CTX(N_CTX), .DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ctx(req_ctx),
  .yield_src(yield_src), .yield_mask(yield_mask), .intercept_en(intercept_en),
  .rsp_valid(rsp_valid), .result(result), .fault(fault), .exc_code(exc_code),
  .deact_valid(deact_valid), .deact_ctx(deact_ctx)
);

// File: tb/sim_yield_ctl.sv
module sim_yield_ctl;
  localparam int N  = 4;
  localparam int DW = 32;
  localparam int CW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [CW-1:0] req_ctx = '0;
  logic signed [DW-1:0] yield_src = '0;
  logic [DW-1:0] yield_mask = '0;
  logic [N-1:0] ctx_dyn = '0, ctx_halt = '0, ctx_act = '0, ctx_dirty = '0;
  logic intercept_en = 1'b0;
  logic rsp_valid, fault, deact_valid;
  logic [DW-1:0] result;
  logic [2:0] exc_code;
  logic [CW-1:0] deact_ctx;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  yield_ctl #(.N_CTX(N), .DW(DW), .CW(CW)) u0 (.*);

  function automatic logic [2:0] model_code(logic signed [DW-1:0] s, logic [DW-1:0] m,
                                            logic ysi, logic dirty);
    if (s == 0) return 3'd0;
    if (s > 0)  return ((s & ~m) != 0) ? 3'd2 : 3'd0;
    if (s == -2) return 3'd0;
    return (ysi && dirty) ? 3'd4 : 3'd0;
  endfunction

  function automatic logic model_deact(logic signed [DW-1:0] s, logic d, logic h, logic a);
    return (s == 0) && d && !h && a;
  endfunction

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [CW-1:0] c, input logic signed [DW-1:0] s,
                       input logic [DW-1:0] m, input string tag);
    logic [2:0] ec;
    logic ed;
    req_valid = 1'b1; req_ctx = c; yield_src = s; yield_mask = m;
    ec = model_code(s, m, intercept_en, ctx_dirty[c]);
    ed = model_deact(s, ctx_dyn[c], ctx_halt[c], ctx_act[c]);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, {tag, " R2 rsp_valid"}, rsp_valid, 1);
    chk(result == (s & m), {tag, " R2 result"}, result, s & m);
    chk(exc_code == ec, {tag, " exc_code"}, exc_code, ec);
    chk(fault == (ec != 0), {tag, " fault"}, fault, ec != 0);
    chk(deact_valid == ed, {tag, " deact_valid"}, deact_valid, ed);
    if (ed) chk(deact_ctx == c, {tag, " R3 deact_ctx"}, deact_ctx, c);
  endtask

  task automatic idle_check(input logic [2:0] held);
    @(negedge clk);
    chk(!rsp_valid && !fault && !deact_valid, "R9 idle pulses", {fault, deact_valid}, 0);
    chk(exc_code == held, "R9 exc_code held", exc_code, held);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [2:0] last;
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!rsp_valid && !fault && !deact_valid && result == 0 && exc_code == 0,
        "R1 reset state", {rsp_valid, fault, deact_valid, exc_code}, 0);

    // R3 release
    ctx_dyn = 4'b1111; ctx_halt = 4'b0000; ctx_act = 4'b1111; ctx_dirty = 4'b1111;
    issue(2'd2, 0, 32'hFFFF_FFFF, "R3 release");
    // R4 halted / not dyn / not active
    ctx_halt = 4'b0010; issue(2'd1, 0, 32'h0, "R4 halted");
    ctx_dyn = 4'b1110; issue(2'd0, 0, 32'h0, "R4 not dyn");
    ctx_act = 4'b0111; issue(2'd3, 0, 32'h0, "R4 inactive");
    // R5 masked wait fault with nonzero result in the same cycle
    issue(2'd0, 32'h0000_0F0F, 32'h0000_000F, "R5 wait illegal");
    idle_check(3'd2);
    idle_check(3'd2);
    // R6 legal wait
    issue(2'd0, 32'h0000_0005, 32'h0000_00FF, "R6 wait legal");
    // R7 privileged yield
    intercept_en = 1'b1; ctx_dirty = 4'b0001;
    issue(2'd0, -5, 32'hFFFF_FFFF, "R7 intercept");
    idle_check(3'd4);
    issue(2'd1, -5, 32'hFFFF_FFFF, "R7 clean ctx");
    intercept_en = 1'b0;
    issue(2'd0, -1, 32'hFFFF_FFFF, "R7 intercept off");
    // R8 -2 never faults
    intercept_en = 1'b1;
    issue(2'd0, -2, 32'hFFFF_FFFF, "R8 nop");
    // R9 back to back: release then fault
    ctx_dyn = 4'b1111; ctx_halt = 4'b0; ctx_act = 4'b1111;
    issue(2'd1, 0, 32'h0, "R9 b2b release");
    issue(2'd1, 32'h1, 32'h0, "R9 b2b fault");
    last = 3'd2;
    idle_check(last);

    // constrained random
    for (int i = 0; i < 400; i++) begin
      logic signed [DW-1:0] s;
      logic [DW-1:0] m;
      int k;
      ctx_dyn = N'($urandom); ctx_halt = N'($urandom); ctx_act = N'($urandom);
      ctx_dirty = N'($urandom); intercept_en = 1'($urandom);
      m = $urandom;
      k = $urandom_range(0, 4);
      case (k)
        0: s = 0;
        1: s = -2;
        2: s = $signed({1'b0, 31'($urandom)}) & $signed(m);
        3: s = $signed({1'b0, 31'($urandom)});
        default: s = $signed({1'b1, 31'($urandom)});
      endcase
      issue(CW'($urandom), s, m, "rand");
      last = exc_code;
      if ($urandom_range(0, 3) == 0) idle_check(last);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule